// File: doc/BRIEF.md
# Conditional LFSR Bus Scrambler

This block hides the values carried on a processor-memory data bus by XORing selected words with a pseudo-random mask. The transmit half holds a linear feedback shift register. For each valid word it either applies the current register pattern as a mask or lets the word through unchanged. The choice is made cycle by cycle by a scramble-request input. A flag line travels with every word and records the choice, so the far end knows which words carry a mask.

The receive half holds an identical shift register. It starts from the same seed and steps once per valid word it receives. When the flag is set, it removes the mask by XORing the word with its own copy of the pattern. Both registers step on every valid word, masked or not, so they stay in step however often the request toggles. Holding the request high gives always-on scrambling. A synchronous reset reloads both registers with the seed.

The two halves sit in one module. The encoded bus outputs are wired to the receive inputs of the matching block on the far side of the bus, or directly back for a loopback.

Top module: `cond_bus_scrambler`

## Requirements
- R1: While `rst` is high at a clock edge, that edge clears `bus_valid`, `bus_flag`, `bus_data`, `rx_valid` and `rx_data` to zero and loads both shift registers with `SEED` (default 32'hACE1_2468).
- R2: A clock edge with `tx_valid` and `tx_scramble` both high sets `bus_data` to `tx_data` XOR the current transmit mask and sets `bus_flag` to 1. These outputs appear one cycle after the inputs.
- R3: A clock edge with `tx_valid` high and `tx_scramble` low sets `bus_data` to `tx_data` unchanged and sets `bus_flag` to 0.
- R4: Each mask is the register state before it steps. The first mask after reset is `SEED`. Each step shifts the register left by one bit, and the new bit 0 is the XOR of bits 31, 21, 1 and 0 (polynomial x^32+x^22+x^2+x+1, `TAPS` = 32'h8020_0003).
- R5: The transmit register steps exactly once per edge with `tx_valid` high, whatever the value of `tx_scramble`. An edge with `tx_valid` low does not step it, clears `bus_valid`, and leaves `bus_data` and `bus_flag` unchanged.
- R6: A clock edge with `rx_in_valid` high sets `rx_data` to `rx_in_data` XOR (`rx_in_flag` ? receive mask : 0). `rx_valid` follows `rx_in_valid` one cycle later. While `rx_in_valid` is low, `rx_data` holds its value.
- R7: The receive register follows the same seed and polynomial as R4. It steps exactly once per edge with `rx_in_valid` high, whether or not `rx_in_flag` is set.
- R8: When the bus outputs are looped back to the receive inputs, `rx_data` returns each original `tx_data` two cycles after it was presented. This holds for any pattern of scramble requests and idle cycles, and for a request held permanently high.
- R9: A reset asserted in the middle of traffic re-seeds both registers. The first word scrambled after the reset is masked with `SEED` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_valid | input | 1 | Transmit word present this cycle |
| tx_scramble | input | 1 | Request to mask the current transmit word |
| tx_data | input | W | Plain transmit word |
| bus_valid | output | 1 | Encoded word valid on the bus |
| bus_flag | output | 1 | Encoded word carries the mask |
| bus_data | output | W | Encoded bus word |
| rx_in_valid | input | 1 | Received bus word valid |
| rx_in_flag | input | 1 | Received word carries the mask |
| rx_in_data | input | W | Received encoded word |
| rx_valid | output | 1 | Recovered word valid |
| rx_data | output | W | Recovered plain word |

## Verification
The encoded bus word and its flag are due one cycle after the transmit inputs. A receive result is due one cycle after its bus inputs, so a looped-back word returns two cycles after it entered. The bench drives inputs on the falling edge and checks on the next falling edge. In that window it compares the bus against the mask predicted for the current transfer. It compares the recovered word against the data of the previous transfer. The mask models step only on valid words, so any extra or missing step in the design shows up as a wrong word on the following transfer.

// File: rtl/cond_bus_scrambler.sv
module cond_bus_scrambler #(
  parameter int          W     = 32,
  parameter logic [W-1:0] TAPS = 32'h8020_0003,
  parameter logic [W-1:0] SEED = 32'hACE1_2468
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tx_valid,
  input  logic         tx_scramble,
  input  logic [W-1:0] tx_data,
  output logic         bus_valid,
  output logic         bus_flag,
  output logic [W-1:0] bus_data,
  input  logic         rx_in_valid,
  input  logic         rx_in_flag,
  input  logic [W-1:0] rx_in_data,
  output logic         rx_valid,
  output logic [W-1:0] rx_data
);

  logic [W-1:0] tx_lfsr, rx_lfsr;
  logic [W-1:0] tx_next, rx_next;
  logic [W-1:0] tx_mask, rx_mask;

  assign tx_next = {tx_lfsr[W-2:0], ^(tx_lfsr & TAPS)};
  assign rx_next = {rx_lfsr[W-2:0], ^(rx_lfsr & TAPS)};

  assign tx_mask = tx_scramble ? tx_lfsr : '0;
  assign rx_mask = rx_in_flag  ? rx_lfsr : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_lfsr   <= SEED;
      bus_valid <= 1'b0;
      bus_flag  <= 1'b0;
      bus_data  <= '0;
    end else begin
      bus_valid <= tx_valid;
      if (tx_valid) begin
        tx_lfsr  <= tx_next;
        bus_flag <= tx_scramble;
        bus_data <= tx_data ^ tx_mask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_lfsr  <= SEED;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= rx_in_valid;
      if (rx_in_valid) begin
        rx_lfsr <= rx_next;
        rx_data <= rx_in_data ^ rx_mask;
      end
    end
  end

endmodule

// File: rtl/cbs_checker.sv
module cbs_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         tx_valid,
  input logic         tx_scramble,
  input logic [W-1:0] tx_data,
  input logic         bus_valid,
  input logic         bus_flag,
  input logic [W-1:0] bus_data,
  input logic         rx_in_valid,
  input logic         rx_in_flag,
  input logic [W-1:0] rx_in_data,
  input logic         rx_valid,
  input logic [W-1:0] rx_data,
  input logic [W-1:0] tx_lfsr,
  input logic [W-1:0] rx_lfsr
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!bus_valid && !bus_flag && !rx_valid));

  p_flag_set_r2: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_scramble) |=> (bus_valid && bus_flag));

  p_plain_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_scramble) |=> (bus_data == $past(tx_data) && !bus_flag));

  p_lfsr_live_r4: assert property (@(posedge clk) disable iff (rst)
    tx_lfsr != '0);

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !tx_valid |=> (!bus_valid && $stable(bus_data) && $stable(bus_flag) && $stable(tx_lfsr)));

  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> tx_lfsr != $past(tx_lfsr));

  p_rx_valid_r6: assert property (@(posedge clk) disable iff (rst)
    rx_in_valid |=> rx_valid);

  p_rx_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !rx_in_valid |=> (!rx_valid && $stable(rx_data)));

  p_rx_plain_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_in_valid && !rx_in_flag) |=> rx_data == $past(rx_in_data));

  p_rx_step_r7: assert property (@(posedge clk) disable iff (rst)
    rx_in_valid |=> rx_lfsr != $past(rx_lfsr));

  p_rx_stall_r7: assert property (@(posedge clk) disable iff (rst)
    !rx_in_valid |=> $stable(rx_lfsr));

endmodule

bind cond_bus_scrambler cbs_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst),
  .tx_valid(tx_valid), .tx_scramble(tx_scramble), .tx_data(tx_data),
  .bus_valid(bus_valid), .bus_flag(bus_flag), .bus_data(bus_data),
  .rx_in_valid(rx_in_valid), .rx_in_flag(rx_in_flag), .rx_in_data(rx_in_data),
  .rx_valid(rx_valid), .rx_data(rx_data),
  .tx_lfsr(tx_lfsr), .rx_lfsr(rx_lfsr)
);

// File: tb/tb_cond_bus_scrambler.sv
`timescale 1ns/1ps
module tb_cond_bus_scrambler;

  localparam logic [31:0] SEED = 32'hACE1_2468;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_valid = 1'b0, tx_scramble = 1'b0;
  logic [31:0] tx_data = '0;
  logic        bus_valid, bus_flag;
  logic [31:0] bus_data;
  logic        loop = 1'b1;
  logic        d_valid = 1'b0, d_flag = 1'b0;
  logic [31:0] d_data = '0;
  logic        rx_in_valid, rx_in_flag;
  logic [31:0] rx_in_data;
  logic        rx_valid;
  logic [31:0] rx_data;

  assign rx_in_valid = loop ? bus_valid : d_valid;
  assign rx_in_flag  = loop ? bus_flag  : d_flag;
  assign rx_in_data  = loop ? bus_data  : d_data;

  always #4 clk = ~clk;

  cond_bus_scrambler dut (
    .clk(clk), .rst(rst),
    .tx_valid(tx_valid), .tx_scramble(tx_scramble), .tx_data(tx_data),
    .bus_valid(bus_valid), .bus_flag(bus_flag), .bus_data(bus_data),
    .rx_in_valid(rx_in_valid), .rx_in_flag(rx_in_flag), .rx_in_data(rx_in_data),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );

  int checks = 0;
  int failures = 0;

  logic [31:0] tm, rm;
  logic        eb_valid, eb_flag, pv;
  logic [31:0] eb_data, pd, er_data;

  localparam logic [33:0] VEC [0:15] = '{
    {1'b1, 1'b1, 32'h0000_0000},
    {1'b1, 1'b0, 32'h1234_5678},
    {1'b1, 1'b1, 32'hFFFF_FFFF},
    {1'b0, 1'b1, 32'hDEAD_BEEF},
    {1'b1, 1'b0, 32'hA5A5_A5A5},
    {1'b0, 1'b0, 32'h0BAD_F00D},
    {1'b1, 1'b1, 32'h0F0F_0F0F},
    {1'b1, 1'b1, 32'h8000_0001},
    {1'b1, 1'b0, 32'h0000_0000},
    {1'b1, 1'b1, 32'hCAFE_1234},
    {1'b1, 1'b1, 32'h1111_2222},
    {1'b1, 1'b1, 32'h3333_4444},
    {1'b1, 1'b1, 32'h5555_6666},
    {1'b0, 1'b0, 32'h0000_0000},
    {1'b1, 1'b0, 32'hFEED_FACE},
    {1'b1, 1'b1, 32'h7777_8888}
  };

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    tx_valid = 0; tx_scramble = 0; tx_data = '0;
    d_valid = 0; d_flag = 0; d_data = '0;
    rst = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 0;
    tm = SEED; rm = SEED;
    eb_valid = 0; eb_flag = 0; eb_data = '0;
    pv = 0; pd = '0; er_data = '0;
  endtask

  task automatic xfer(input logic v, input logic f, input logic [31:0] d, input string req);
    tx_valid = v; tx_scramble = f; tx_data = d;
    @(posedge clk); @(negedge clk);
    if (v) begin
      eb_data = f ? (d ^ tm) : d;
      eb_flag = f;
      tm = nxt(tm);
    end
    eb_valid = v;
    chk(req, "bus_valid", {31'd0, bus_valid}, {31'd0, eb_valid});
    chk(req, "bus_flag",  {31'd0, bus_flag},  {31'd0, eb_flag});
    chk(req, "bus_data",  bus_data, eb_data);
    if (pv) er_data = pd;
    chk("R8", "rx_valid loop", {31'd0, rx_valid}, {31'd0, pv});
    chk("R8", "rx_data loop",  rx_data, er_data);
    pv = v;
    if (v) pd = d;
  endtask

  task automatic rxstep(input logic v, input logic fl, input logic [31:0] d, input string req);
    d_valid = v; d_flag = fl; d_data = d;
    @(posedge clk); @(negedge clk);
    if (v) begin
      er_data = fl ? (d ^ rm) : d;
      rm = nxt(rm);
    end
    chk(req, "rx_valid", {31'd0, rx_valid}, {31'd0, v});
    chk(req, "rx_data",  rx_data, er_data);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    loop = 1;
    do_reset();
    // R1: reset state
    chk("R1", "bus_valid", {31'd0, bus_valid}, 32'd0);
    chk("R1", "bus_flag",  {31'd0, bus_flag},  32'd0);
    chk("R1", "bus_data",  bus_data, 32'd0);
    chk("R1", "rx_valid",  {31'd0, rx_valid},  32'd0);
    chk("R1", "rx_data",   rx_data, 32'd0);

    // R4: first mask is the seed, second is one step later
    xfer(1, 1, 32'h0, "R4");
    chk("R4", "first mask", bus_data, SEED);
    xfer(1, 1, 32'h0, "R4");
    chk("R4", "second mask", bus_data, nxt(SEED));
    xfer(0, 0, 32'h0, "R5");
    xfer(0, 0, 32'h0, "R8");

    // R2/R3/R5/R8: vector table in loopback
    do_reset();
    for (int i = 0; i < 16; i++) begin
      xfer(VEC[i][33], VEC[i][32], VEC[i][31:0],
           !VEC[i][33] ? "R5" : (VEC[i][32] ? "R2" : "R3"));
    end
    xfer(0, 0, 32'h0, "R5");

    // R5: unscrambled words still step the mask
    do_reset();
    xfer(1, 0, 32'h1357_9BDF, "R3");
    xfer(1, 0, 32'h2468_ACE0, "R3");
    xfer(0, 1, 32'hFFFF_0000, "R5");
    xfer(1, 1, 32'h0, "R5");
    chk("R5", "mask after two plain words", bus_data, nxt(nxt(SEED)));
    xfer(0, 0, 32'h0, "R8");

    // R8: request held high for a long run
    for (int i = 0; i < 40; i++) begin
      xfer(1, 1, 32'h0100_0000 * i + 32'h0000_0F00 + i, "R2");
    end
    xfer(0, 0, 32'h0, "R8");

    // R9: reset in mid-stream re-seeds
    xfer(1, 1, 32'hAAAA_5555, "R2");
    do_reset();
    xfer(1, 1, 32'h0, "R9");
    chk("R9", "mask after re-reset", bus_data, SEED);
    xfer(0, 0, 32'h0, "R9");
    chk("R9", "rx recovered after re-reset", rx_data, 32'h0);

    // R6/R7: receiver driven directly
    loop = 0;
    do_reset();
    rxstep(1, 1, 32'h0, "R6");
    chk("R6", "unmask uses seed", rx_data, SEED);
    rxstep(1, 0, 32'h1234_ABCD, "R7");
    rxstep(0, 1, 32'hFFFF_FFFF, "R6");
    rxstep(1, 1, 32'h0, "R7");
    chk("R7", "rx mask after plain word", rx_data, nxt(nxt(SEED)));
    rxstep(1, 1, 32'hF0F0_F0F0, "R6");
    rxstep(0, 0, 32'h0, "R6");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule